// File: doc/BRIEF.md
# Serial Readback Shifter with Borrowed Pins

This block streams a stored nonvolatile configuration image out of the chip while it is in readback mode. An upstream command decoder marks entry into readback with a one-cycle `start` pulse. From then on, the chip's serial data input pin is no longer treated as data. It serves as a slow shift clock supplied from off chip. The frequency output pin is taken away from the oscillator and carries serial data instead.

The borrowed pin clock is sampled into the core clock domain through a short synchronizer, and its rising and falling edges are detected there.

- The first rising edge after entry captures the whole image into a shift register.
- Each following falling edge presents the next image bit on the output, most significant bit first.
- Once all bits of the frame have been presented, one more falling edge ends readback. The output pin then goes back to the oscillator.

There is no stop command: the exit happens on the exact edge count. An asynchronous reset aborts readback at any point.

Top module: `rb_shifter`

## Requirements
- R1: While reset is asserted, and after its release with no command, `active` and `out_sel` are 0 and `fout` equals `osc_in`.
- R2: A `start` pulse while idle sets `active` and `out_sel` to 1 at the next clock edge. `fout` then shows the serial bit, which is 0 until the first bit is presented.
- R3: A falling edge on `sdata_pin` after `start` but before the first rising edge is ignored. `fout` stays 0 and the bit count does not advance, so a later full frame still needs exactly FRAME+1 falling edges.
- R4: The first rising edge after `start` copies `image` into the shift register. Changes on `image` after that capture do not alter the bits shifted out.
- R5: The k-th falling edge after the capture, for k from 1 to FRAME, drives `fout` to `image` bit FRAME-k (MSB first, bit FRAME-1 first).
- R6: Rising edges after the capture leave `fout` unchanged.
- R7: Falling edge number FRAME+1 after the capture clears `active` and `out_sel`, and `fout` follows `osc_in` again.
- R8: A `start` pulse while readback is active is ignored. The frame continues with its bit order and bit count unchanged.
- R9: Asserting `rst_n` low mid-frame clears `out_sel` and `active` at once, without waiting for a clock edge, and `fout` follows `osc_in`.
- R10: Edges on `sdata_pin` while idle have no effect; `fout` keeps following `osc_in`.
- R11: A level change on `sdata_pin` is acted on at the third rising clock edge after it is set up before a clock edge. With the default two-stage synchronizer, that is two edges of synchronizer and one of state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle readback entry pulse from the command decoder |
| sdata_pin | input | 1 | Serial data pin, used as the shift clock during readback |
| osc_in | input | 1 | Oscillator signal normally driven on the output pin |
| image | input | FRAME | Stored nonvolatile image |
| fout | output | 1 | Output pin: oscillator, or serial data during readback |
| out_sel | output | 1 | Output mux select, 1 while serial data is driven |
| active | output | 1 | Readback in progress |

## Verification
Results have two kinds of timing.

- **Start and reset.** The `start` response is due one clock edge after the pulse. The reset abort is due immediately, with no clock edge.
- **Pin edges.** Every pin-driven result (capture, bit presentation, exit) comes three clock edges after the level change, because of the synchronizer and the edge register.

The bench changes `sdata_pin` on a falling clock edge and holds it for four clocks. It samples `fout`, `active` and `out_sel` only on a falling edge after that window, so each check reads the settled value and never sits on an edge. The `start` and reset checks are sampled at the next falling clock edge and one time unit after the reset assertion, respectively.

// File: rtl/rb_pkg.sv
package rb_pkg;

  typedef enum logic [1:0] {
    RB_IDLE  = 2'd0,
    RB_ARMED = 2'd1,
    RB_SHIFT = 2'd2
  } rb_state_e;

  // Width of the falling-edge counter: must hold FRAME+1 (the exit edge).
  function automatic int unsigned rb_cnt_width(input int unsigned frame);
    return $clog2(frame + 2);
  endfunction

  // Index of the image bit presented on falling edge k (1-based).
  function automatic int unsigned rb_bit_index(input int unsigned frame,
                                               input int unsigned k);
    return frame - k;
  endfunction

endpackage

// File: rtl/rb_pin_edges.sv
module rb_pin_edges #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic rise_evt,
  output logic fall_evt
);

  logic [STAGES-1:0] sync_q;
  logic              prev_q;
  logic              pin_s;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= pin;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[STAGES-2:0], pin};
      end
    end
  endgenerate

  assign pin_s = sync_q[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= pin_s;
  end

  assign rise_evt = pin_s & ~prev_q;
  assign fall_evt = ~pin_s & prev_q;

endmodule

// File: rtl/rb_ctrl.sv
module rb_ctrl
  import rb_pkg::*;
#(
  parameter int unsigned FRAME = 59,
  localparam int unsigned CW   = rb_cnt_width(FRAME)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          rise_evt,
  input  logic          fall_evt,
  output logic          active,
  output logic          load_evt,
  output logic          present_evt,
  output logic          exit_evt,
  output logic [CW-1:0] fall_cnt
);

  rb_state_e state_q, state_d;
  logic [CW-1:0] cnt_d;
  logic          last_bit_done;

  assign last_bit_done = (fall_cnt == CW'(FRAME));

  assign load_evt    = (state_q == RB_ARMED) && rise_evt;
  assign exit_evt    = (state_q == RB_SHIFT) && fall_evt && last_bit_done;
  assign present_evt = (state_q == RB_SHIFT) && fall_evt && !last_bit_done;

  always_comb begin
    state_d = state_q;
    cnt_d   = fall_cnt;
    unique case (state_q)
      RB_IDLE: begin
        cnt_d = '0;
        if (start) state_d = RB_ARMED;
      end
      RB_ARMED: begin
        if (load_evt) state_d = RB_SHIFT;
      end
      RB_SHIFT: begin
        if (exit_evt) begin
          state_d = RB_IDLE;
          cnt_d   = '0;
        end else if (present_evt) begin
          cnt_d = fall_cnt + CW'(1);
        end
      end
      default: begin
        state_d = RB_IDLE;
        cnt_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= RB_IDLE;
      fall_cnt <= '0;
    end else begin
      state_q  <= state_d;
      fall_cnt <= cnt_d;
    end
  end

  assign active = (state_q != RB_IDLE);

endmodule

// File: rtl/rb_shreg.sv
module rb_shreg #(
  parameter int unsigned FRAME = 59
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [FRAME-1:0] image,
  input  logic             load,
  input  logic             present,
  input  logic             clear,
  output logic             sr_msb,
  output logic             ser_bit
);

  logic [FRAME-1:0] sr_q;
  logic             ser_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q  <= '0;
      ser_q <= 1'b0;
    end else if (clear) begin
      sr_q  <= '0;
      ser_q <= 1'b0;
    end else if (load) begin
      sr_q  <= image;
    end else if (present) begin
      ser_q <= sr_q[FRAME-1];
      sr_q  <= {sr_q[FRAME-2:0], 1'b0};
    end
  end

  assign sr_msb  = sr_q[FRAME-1];
  assign ser_bit = ser_q;

endmodule

// File: rtl/rb_shifter.sv
module rb_shifter
  import rb_pkg::*;
#(
  parameter int unsigned FRAME       = 59,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned CW         = rb_cnt_width(FRAME)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             sdata_pin,
  input  logic             osc_in,
  input  logic [FRAME-1:0] image,
  output logic             fout,
  output logic             out_sel,
  output logic             active
);

  logic          rise_evt;
  logic          fall_evt;
  logic          load_evt;
  logic          present_evt;
  logic          exit_evt;
  logic [CW-1:0] fall_cnt;
  logic          sr_msb;
  logic          ser_bit;
  logic          sel_q;

  rb_pin_edges #(.STAGES(SYNC_STAGES)) u_edges (
    .clk      (clk),
    .rst_n    (rst_n),
    .pin      (sdata_pin),
    .rise_evt (rise_evt),
    .fall_evt (fall_evt)
  );

  rb_ctrl #(.FRAME(FRAME)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .rise_evt    (rise_evt),
    .fall_evt    (fall_evt),
    .active      (active),
    .load_evt    (load_evt),
    .present_evt (present_evt),
    .exit_evt    (exit_evt),
    .fall_cnt    (fall_cnt)
  );

  rb_shreg #(.FRAME(FRAME)) u_shreg (
    .clk     (clk),
    .rst_n   (rst_n),
    .image   (image),
    .load    (load_evt),
    .present (present_evt),
    .clear   (exit_evt),
    .sr_msb  (sr_msb),
    .ser_bit (ser_bit)
  );

  // Output steering register: set on accepted entry, cleared on exit.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  sel_q <= 1'b0;
    else if (exit_evt)           sel_q <= 1'b0;
    else if (start && !active)   sel_q <= 1'b1;
  end

  assign out_sel = sel_q;
  assign fout    = sel_q ? ser_bit : osc_in;

endmodule

// File: rtl/rb_shifter_chk.sv
module rb_shifter_chk #(
  parameter int unsigned FRAME = 59,
  parameter int unsigned CW    = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             osc_in,
  input logic [FRAME-1:0] image,
  input logic             fout,
  input logic             out_sel,
  input logic             active,
  input logic             fall_evt,
  input logic             load_evt,
  input logic             present_evt,
  input logic             exit_evt,
  input logic [CW-1:0]    fall_cnt,
  input logic             sr_msb,
  input logic             ser_bit
);

  // R2
  start_enters_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !active) |=> (active && out_sel));

  // R4
  capture_msb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> (sr_msb == $past(image[FRAME-1])));

  // R5
  present_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    present_evt |=> (ser_bit == $past(sr_msb)));

  // R7
  exit_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exit_evt |-> (fall_evt && fall_cnt == CW'(FRAME)));

  // R7
  exit_restores_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exit_evt |=> (!active && !out_sel));

  // R8
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && active && !exit_evt) |=> (active && $stable(fall_cnt)) || $past(present_evt));

  // R10
  idle_follows_osc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> (fout == osc_in));

  // R5
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fall_cnt <= CW'(FRAME));

endmodule

bind rb_shifter rb_shifter_chk #(.FRAME(FRAME), .CW(CW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start       (start),
  .osc_in      (osc_in),
  .image       (image),
  .fout        (fout),
  .out_sel     (out_sel),
  .active      (active),
  .fall_evt    (fall_evt),
  .load_evt    (load_evt),
  .present_evt (present_evt),
  .exit_evt    (exit_evt),
  .fall_cnt    (fall_cnt),
  .sr_msb      (sr_msb),
  .ser_bit     (ser_bit)
);

// File: tb/rb_shifter_tb.sv
module rb_shifter_tb;

  localparam int unsigned FRAME = 59;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start = 1'b0;
  logic             sdata_pin = 1'b0;
  logic             osc_in = 1'b0;
  logic [FRAME-1:0] image = '0;
  logic             fout;
  logic             out_sel;
  logic             active;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  rb_shifter #(.FRAME(FRAME), .SYNC_STAGES(2)) u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .sdata_pin (sdata_pin),
    .osc_in    (osc_in),
    .image     (image),
    .fout      (fout),
    .out_sel   (out_sel),
    .active    (active)
  );

  always #10 clk = ~clk;

  function automatic logic exp_bit(input logic [FRAME-1:0] img, input int k);
    logic [FRAME-1:0] t;
    t = img << (k - 1);
    return t[FRAME-1];
  endfunction

  function automatic logic [FRAME-1:0] rand_image();
    logic [FRAME-1:0] v;
    v = {$urandom(), $urandom()};
    return v;
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  // Change pin level on a falling clock edge and let it settle (R11: 3 edges).
  task automatic pin_to(input logic v);
    @(negedge clk);
    sdata_pin = v;
    repeat (4) @(negedge clk);
  endtask

  task automatic pulse_start();
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic check_idle(input string req);
    osc_in = ~osc_in;
    #1;
    check(req, active, 1'b0);
    check(req, out_sel, 1'b0);
    check(req, fout, osc_in);
  endtask

  // Full frame. stray: pin starts high, so a falling edge precedes the capture.
  task automatic run_frame(input logic [FRAME-1:0] img, input bit stray,
                           input bit late_start);
    logic [FRAME-1:0] cap;
    if (stray) pin_to(1'b1);
    else       pin_to(1'b0);
    check_idle("R10");
    image = img;
    cap   = img;
    pulse_start();
    check("R2", active, 1'b1);
    check("R2", out_sel, 1'b1);
    check("R2", fout, 1'b0);
    if (stray) begin
      pin_to(1'b0);
      check("R3", fout, 1'b0);
      check("R3", active, 1'b1);
    end
    pin_to(1'b1);
    check("R4", fout, 1'b0);
    image = rand_image();
    for (int k = 1; k <= FRAME; k++) begin
      pin_to(1'b0);
      check("R5", fout, exp_bit(cap, k));
      if (late_start && k == 20) begin
        pulse_start();
        check("R8", active, 1'b1);
        check("R8", fout, exp_bit(cap, k));
      end
      pin_to(1'b1);
      check("R6", fout, exp_bit(cap, k));
    end
    check("R7", active, 1'b1);
    pin_to(1'b0);
    check_idle("R7");
  endtask

  initial begin
    void'($urandom(32'h1d5e_0a7b));
    #1;
    check_idle("R1");
    repeat (3) @(negedge clk);
    check_idle("R1");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check_idle("R1");

    // R10: pin toggling while idle
    pin_to(1'b1);
    check_idle("R10");
    pin_to(1'b0);
    check_idle("R10");

    // R11: edge acted on exactly at third clock edge
    image = {1'b1, {(FRAME-1){1'b0}}};
    pulse_start();
    @(negedge clk); sdata_pin = 1'b1;
    repeat (4) @(negedge clk);
    @(negedge clk); sdata_pin = 1'b0;
    repeat (2) @(negedge clk);
    check("R11", fout, 1'b0);
    @(negedge clk);
    check("R11", fout, 1'b1);

    // R9: async abort mid-frame
    repeat (2) @(negedge clk);
    #3 rst_n = 1'b0;
    #1;
    check("R9", out_sel, 1'b0);
    check("R9", active, 1'b0);
    check("R9", fout, osc_in);
    @(negedge clk);
    rst_n = 1'b1;
    pin_to(1'b0);
    check_idle("R9");

    // directed patterns
    run_frame({FRAME{1'b1}}, 1'b0, 1'b0);
    run_frame({(FRAME+1)/2{2'b10}}, 1'b1, 1'b0);
    run_frame({1'b1, {(FRAME-2){1'b0}}, 1'b1}, 1'b0, 1'b1);
    // random frames
    for (int n = 0; n < 12; n++)
      run_frame(rand_image(), ($urandom() & 1) != 0, ($urandom() % 3) == 0);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule